// File: doc/BRIEF.md
# Serial Register Port with Interrupt Status

This block is the host-facing serial slave of a measurement chip. A host selects the chip with an active-low chip select and clocks in a command byte. Bit 7 of that byte is the direction and bits 5:0 are the register address. The command is followed by one to three data bytes, with the most significant byte first. Writes come out on a one-cycle register write bus. Reads are served from a small register file that holds an interrupt enable register, two views of the interrupt status register, a scratch register and the latest waveform sample.

Event pulses from the measurement logic set status flags. An active-low interrupt line asserts while any enabled flag is set, except the power-on flag. That flag is set at reset and can never reach the line. Reading the status through the take-address returns the flags and clears them, which releases the line. Reading through the peek-address leaves the flags untouched.

The serial pins are oversampled by the system clock through two-stage synchronizers. A link state machine has these states:
- ST_IDLE: deselected.
- ST_CMD: shifting the command byte.
- ST_WDATA: shifting write data.
- ST_RDATA: driving read data.
- ST_DONE: all bytes served; extra clocks are ignored.

It has these transitions:
- Any state goes to ST_IDLE whenever chip select is high.
- ST_IDLE goes to ST_CMD when chip select is low.
- ST_CMD goes to ST_WDATA or ST_RDATA on the eighth command bit, chosen by bit 7.
- Both data states go to ST_DONE on the last data bit.

Top module: `spi_regport`

## Requirements
- R1: Command byte bit 7 = 1 selects a write and 0 a read; bits 5:0 are the address; bit 6 is ignored.
- R2: The serial data input is sampled on the falling edge of the serial clock and read data is launched on the rising edge. Bytes go most significant byte first, each byte MSB first.
- R3: `miso_oe` is low (and `miso` high impedance) except during the data phase of a read.
- R4: Register lengths: 0x01 enable, 0x02 status peek and 0x03 status take are one byte; 0x04 scratch is two bytes; 0x05 waveform is three bytes. Every other address is one byte and reads as zero.
- R5: After the last bit of a write, `wr_valid` pulses for one cycle with the address and the right-aligned data. Writes to 0x01 and 0x04 update those registers; writes to other addresses change no readable register.
- R6: `irq_n` is low exactly while a status flag other than bit 0 is set and enabled in the enable register.
- R7: Status bit 0 (power flag) is set by reset and by `evt[0]`, and never pulls `irq_n` low.
- R8: A read of 0x03 returns the flags and clears them; a read of 0x02 returns them without clearing.
- R9: A flag event in the same cycle as the clearing read stays set afterwards.
- R10: `smp_valid` stores a sample and sets status bit 1. A current sample (`smp_is_volt`=0) is kept as 24 bits. A voltage sample keeps its low 16 bits, with the upper byte zero rather than sign-extended.
- R11: Chip select going high mid-transfer aborts it with no write; the next transfer starts with a command byte.
- R12: After reset, `irq_n` = 1, `miso_oe` = 0, `wr_valid` = 0, enable = 0x00 and status = 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle high |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, high impedance when not driving |
| miso_oe | output | 1 | Pad enable for `miso` |
| irq_n | output | 1 | Interrupt request, active low |
| evt | input | NUM_FLAGS | Flag event pulses, one per status bit |
| smp_valid | input | 1 | New waveform sample strobe |
| smp_is_volt | input | 1 | Sample comes from a voltage channel |
| smp_data | input | 24 | Waveform sample |
| wr_valid | output | 1 | Register write strobe |
| wr_addr | output | 6 | Register write address |
| wr_data | output | 24 | Register write data, right-aligned |

## Verification
The hardest case to reach is an event that lands in exactly the cycle in which the take-read clears the status. That cycle sits several synchronizer stages behind the eighth falling serial clock edge, so it cannot be targeted from the pins directly. The bench therefore sweeps a single-cycle event pulse across a window of offsets after that edge, running one clearing read per offset. For every offset, the event must appear either in the returned byte or in the flags afterwards, and never in both. Because the window covers the cycles before, at and after the clear, one offset must hit the same-cycle case.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int ADDR_W = 6;
    localparam int CMD_W  = 8;
    localparam int WORD_W = 24;
    localparam int LEN_W  = 2;
    localparam int CNT_W  = 5;

    localparam logic [ADDR_W-1:0] A_IRQ_EN    = 6'h01;
    localparam logic [ADDR_W-1:0] A_STAT_PEEK = 6'h02;
    localparam logic [ADDR_W-1:0] A_STAT_TAKE = 6'h03;
    localparam logic [ADDR_W-1:0] A_SCRATCH   = 6'h04;
    localparam logic [ADDR_W-1:0] A_WAVE      = 6'h05;

    localparam int F_PWR  = 0;
    localparam int F_WAVE = 1;

    localparam int SCRATCH_W = 16;
    localparam int VOLT_W    = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } link_state_t;

    // Number of data bytes that follow the command for a given address.
    function automatic logic [LEN_W-1:0] reg_bytes(input logic [ADDR_W-1:0] a);
        logic [LEN_W-1:0] n;
        case (a)
            A_SCRATCH: n = 2'd2;
            A_WAVE:    n = 2'd3;
            default:   n = 2'd1;
        endcase
        return n;
    endfunction

    // Put the first byte to be sent into the top of the word.
    function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] d,
                                                     input logic [LEN_W-1:0] n);
        logic [WORD_W-1:0] r;
        case (n)
            2'd1:    r = {d[7:0], 16'h0000};
            2'd2:    r = {d[15:0], 8'h00};
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int               WIDTH  = 3,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] INIT   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{INIT[i]}};
                end else begin
                    chain <= {chain[STAGES-2:0], d[i]};
                end
            end
            assign q[i] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_regport_link.sv
module spi_regport_link
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_strobe,
    output logic              miso_q,
    output logic              miso_oe,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data
);

    localparam int RX_W = WORD_W - 1;

    link_state_t       st_q, st_nx;
    logic              sclk_d;
    logic              fall, rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  phase_bits;
    logic [RX_W-1:0]   rx;
    logic [WORD_W-1:0] tx;
    logic [ADDR_W-1:0] addr_q;
    logic [CMD_W-1:0]  cmd_byte;
    logic [LEN_W-1:0]  cmd_len;
    logic              cmd_done, data_done;
    logic              unused_bit6;

    assign fall      = sclk_d & ~sclk_s;
    assign rise      = ~sclk_d & sclk_s;
    assign cmd_byte  = {rx[CMD_W-2:0], mosi_s};
    assign cmd_len   = reg_bytes(cmd_byte[ADDR_W-1:0]);
    assign cmd_done  = (st_q == ST_CMD) && fall && (bit_cnt == CNT_W'(CMD_W - 1));
    assign data_done = ((st_q == ST_WDATA) || (st_q == ST_RDATA)) && fall
                       && (bit_cnt == phase_bits - CNT_W'(1));
    assign rd_addr   = cmd_byte[ADDR_W-1:0];
    assign rd_strobe = cmd_done && !cmd_byte[CMD_W-1];
    assign unused_bit6 = cmd_byte[CMD_W-2];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // Next state
    always_comb begin
        st_nx = st_q;
        if (cs_n_s) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_nx = ST_CMD;
                ST_CMD:   if (cmd_done) st_nx = cmd_byte[CMD_W-1] ? ST_WDATA : ST_RDATA;
                ST_WDATA: if (data_done) st_nx = ST_DONE;
                ST_RDATA: if (data_done) st_nx = ST_DONE;
                ST_DONE:  st_nx = ST_DONE;
            endcase
        end
    end

    // Shifters and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d     <= 1'b1;
            bit_cnt    <= '0;
            phase_bits <= CNT_W'(8);
            rx         <= '0;
            tx         <= '0;
            addr_q     <= '0;
            miso_q     <= 1'b0;
            miso_oe    <= 1'b0;
            wr_valid   <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            sclk_d   <= sclk_s;
            wr_valid <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
                miso_oe <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        bit_cnt <= '0;
                        rx      <= '0;
                        miso_oe <= 1'b0;
                    end
                    ST_CMD: begin
                        if (fall) begin
                            if (cmd_done) begin
                                bit_cnt    <= '0;
                                rx         <= '0;
                                addr_q     <= cmd_byte[ADDR_W-1:0];
                                phase_bits <= {cmd_len, 3'b000};
                                tx         <= left_align(rd_word, cmd_len);
                            end else begin
                                bit_cnt <= bit_cnt + CNT_W'(1);
                                rx      <= {rx[RX_W-2:0], mosi_s};
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (fall) begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                            rx      <= {rx[RX_W-2:0], mosi_s};
                            if (data_done) begin
                                wr_valid <= 1'b1;
                                wr_addr  <= addr_q;
                                wr_data  <= {rx, mosi_s};
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (rise) begin
                            miso_q  <= tx[WORD_W-1];
                            tx      <= {tx[WORD_W-2:0], 1'b0};
                            miso_oe <= 1'b1;
                        end
                        if (fall) begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                        if (data_done) begin
                            miso_oe <= 1'b0;
                        end
                    end
                    ST_DONE: begin
                        miso_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs
    import spi_regport_pkg::*;
#(
    parameter int NUM_FLAGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 smp_valid,
    input  logic                 smp_is_volt,
    input  logic [WORD_W-1:0]    smp_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [NUM_FLAGS-1:0] stat_q,
    output logic [NUM_FLAGS-1:0] irq_en,
    output logic [WORD_W-1:0]    wave_q,
    output logic [WORD_W-1:0]    rd_word
);

    localparam int PAD_W = WORD_W - VOLT_W;

    logic [SCRATCH_W-1:0] scratch_q;
    logic                 unused_wr_hi;

    assign unused_wr_hi = ^wr_data[WORD_W-1:SCRATCH_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en    <= '0;
            scratch_q <= '0;
        end else if (wr_valid) begin
            if (wr_addr == A_IRQ_EN) begin
                irq_en <= wr_data[NUM_FLAGS-1:0];
            end
            if (wr_addr == A_SCRATCH) begin
                scratch_q <= wr_data[SCRATCH_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_q <= '0;
        end else if (smp_valid) begin
            if (smp_is_volt) begin
                wave_q <= {{PAD_W{1'b0}}, smp_data[VOLT_W-1:0]};
            end else begin
                wave_q <= smp_data;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_IRQ_EN:    rd_word = WORD_W'(irq_en);
            A_STAT_PEEK: rd_word = WORD_W'(stat_q);
            A_STAT_TAKE: rd_word = WORD_W'(stat_q);
            A_SCRATCH:   rd_word = WORD_W'(scratch_q);
            A_WAVE:      rd_word = wave_q;
            default:     rd_word = '0;
        endcase
    end

endmodule

// File: rtl/spi_regport_irq.sv
module spi_regport_irq
    import spi_regport_pkg::*;
#(
    parameter int NUM_FLAGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] evt,
    input  logic                 smp_valid,
    input  logic                 clear,
    input  logic [NUM_FLAGS-1:0] irq_en,
    output logic [NUM_FLAGS-1:0] stat_q,
    output logic                 irq_n
);

    localparam logic [NUM_FLAGS-1:0] PWR_BIT    = NUM_FLAGS'(1) << F_PWR;
    localparam logic [NUM_FLAGS-1:0] ROUTE_MASK = ~PWR_BIT;

    logic [NUM_FLAGS-1:0] set_v;

    always_comb begin
        set_v         = evt;
        set_v[F_WAVE] = evt[F_WAVE] | smp_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= PWR_BIT;
        end else begin
            stat_q <= (clear ? '0 : stat_q) | set_v;
        end
    end

    assign irq_n = ~|(stat_q & irq_en & ROUTE_MASK);

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int NUM_FLAGS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 mosi,
    output logic                 miso,
    output logic                 miso_oe,
    output logic                 irq_n,
    input  logic [NUM_FLAGS-1:0] evt,
    input  logic                 smp_valid,
    input  logic                 smp_is_volt,
    input  logic [23:0]          smp_data,
    output logic                 wr_valid,
    output logic [5:0]           wr_addr,
    output logic [23:0]          wr_data
);

    logic [2:0]           pins_s;
    logic                 cs_n_s, sclk_s, mosi_s;
    logic [ADDR_W-1:0]    rd_addr;
    logic                 rd_strobe;
    logic [WORD_W-1:0]    rd_word;
    logic                 miso_q;
    logic                 stat_clr;
    logic [NUM_FLAGS-1:0] stat_q;
    logic [NUM_FLAGS-1:0] irq_en;
    logic [WORD_W-1:0]    wave_q;

    spi_regport_sync #(
        .WIDTH (3),
        .STAGES(SYNC_STAGES),
        .INIT  (3'b011)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({mosi, sclk, cs_n}),
        .q    (pins_s)
    );

    assign cs_n_s = pins_s[0];
    assign sclk_s = pins_s[1];
    assign mosi_s = pins_s[2];

    spi_regport_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (cs_n_s),
        .sclk_s   (sclk_s),
        .mosi_s   (mosi_s),
        .rd_word  (rd_word),
        .rd_addr  (rd_addr),
        .rd_strobe(rd_strobe),
        .miso_q   (miso_q),
        .miso_oe  (miso_oe),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    assign stat_clr = rd_strobe && (rd_addr == A_STAT_TAKE);

    spi_regport_regs #(.NUM_FLAGS(NUM_FLAGS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .smp_valid  (smp_valid),
        .smp_is_volt(smp_is_volt),
        .smp_data   (smp_data),
        .rd_addr    (rd_addr),
        .stat_q     (stat_q),
        .irq_en     (irq_en),
        .wave_q     (wave_q),
        .rd_word    (rd_word)
    );

    spi_regport_irq #(.NUM_FLAGS(NUM_FLAGS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .smp_valid(smp_valid),
        .clear    (stat_clr),
        .irq_en   (irq_en),
        .stat_q   (stat_q),
        .irq_n    (irq_n)
    );

    assign miso = miso_oe ? miso_q : 1'bz;

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
    parameter int NUM_FLAGS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_FLAGS-1:0] evt,
    input logic                 smp_valid,
    input logic                 smp_is_volt,
    input logic [NUM_FLAGS-1:0] stat,
    input logic                 clr,
    input logic                 irq_n,
    input logic                 miso_oe,
    input logic                 cs_n_s,
    input logic                 wr_valid,
    input logic [23:0]          wave
);

    localparam logic [NUM_FLAGS-1:0] PWR_ONLY = NUM_FLAGS'(1);

    AST_DESELECT_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n) cs_n_s |=> !miso_oe); // R3
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) !irq_n |-> (|stat[NUM_FLAGS-1:1])); // R6
    AST_PWR_FLAG_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (stat == PWR_ONLY) |-> irq_n); // R7
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr && evt == '0 && !smp_valid) |=> (stat == '0)); // R8
    AST_RACE_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n) clr |=> ((stat & $past(evt)) == $past(evt))); // R9
    AST_VOLT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n) (smp_valid && smp_is_volt) |=> (wave[23:16] == 8'h00)); // R10
    AST_SINGLE_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |=> !wr_valid); // R5

endmodule

bind spi_regport spi_regport_chk #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .smp_valid  (smp_valid),
    .smp_is_volt(smp_is_volt),
    .stat       (stat_q),
    .clr        (stat_clr),
    .irq_n      (irq_n),
    .miso_oe    (miso_oe),
    .cs_n_s     (cs_n_s),
    .wr_valid   (wr_valid),
    .wave       (wave_q)
);

// File: tb/spi_regport_test.sv
`timescale 1ns/1ps
module spi_regport_test;

    localparam int NF   = 8;
    localparam int HALF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b1;
    logic          mosi = 1'b0;
    wire           miso;
    logic          miso_oe;
    logic          irq_n;
    logic [NF-1:0] evt = '0;
    logic          smp_valid = 1'b0;
    logic          smp_is_volt = 1'b0;
    logic [23:0]   smp_data = '0;
    logic          wr_valid;
    logic [5:0]    wr_addr;
    logic [23:0]   wr_data;

    int            n_checks = 0;
    int            n_fails  = 0;
    int            wr_count = 0;
    logic [5:0]    last_wr_addr = '0;
    logic [23:0]   last_wr_data = '0;
    logic          mark = 1'b0;
    logic          finished = 1'b0;

    always #2 clk = ~clk;

    spi_regport #(.NUM_FLAGS(NF)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .irq_n(irq_n), .evt(evt),
        .smp_valid(smp_valid), .smp_is_volt(smp_is_volt), .smp_data(smp_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (wr_valid) begin
            wr_count     <= wr_count + 1;
            last_wr_addr <= wr_addr;
            last_wr_data <= wr_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic spi_xfer(input logic [7:0] cmd, input int nbytes, input logic [23:0] wdata,
                            input int stop_after, output logic [23:0] rdata, output logic oe_bad);
        int total;
        logic [31:0] fr;
        total  = 8 + 8 * nbytes;
        fr     = {cmd, 24'(wdata << (8 * (3 - nbytes)))};
        rdata  = '0;
        oe_bad = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < total; i++) begin
            if (stop_after >= 0 && i == stop_after) break;
            mosi = fr[31-i];
            repeat (HALF) @(negedge clk);
            if (i >= 8) begin
                rdata = {rdata[22:0], miso};
                if (cmd[7] == miso_oe) oe_bad = 1'b1;
            end else if (miso_oe) begin
                oe_bad = 1'b1;
            end
            sclk = 1'b0;
            if (i == 7) mark = 1'b1;
            repeat (HALF) @(negedge clk);
            mark = 1'b0;
            sclk = 1'b1;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        if (miso_oe) oe_bad = 1'b1;
    endtask

    task automatic rd(input logic [5:0] a, input int n, output logic [23:0] v);
        logic bad;
        spi_xfer({2'b00, a}, n, 24'h0, -1, v, bad);
    endtask

    task automatic wr(input logic [5:0] a, input int n, input logic [23:0] d);
        logic [23:0] v;
        logic bad;
        spi_xfer({2'b10, a}, n, d, -1, v, bad);
    endtask

    task automatic pulse_evt(input int b);
        @(negedge clk) evt[b] = 1'b1;
        @(negedge clk) evt[b] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [23:0] v;
        chk("R12 irq_n", irq_n, 1);
        chk("R12 miso_oe", miso_oe, 0);
        chk("R12 wr_valid", wr_valid, 0);
        rd(6'h02, 1, v);
        chk("R12 R7 status after reset", v, 24'h01);
        rd(6'h01, 1, v);
        chk("R12 enable after reset", v, 24'h00);
    endtask

    task automatic t_write_read;
        logic [23:0] v;
        int c0;
        c0 = wr_count;
        wr(6'h04, 2, 24'h00A55A);
        chk("R5 one write pulse", wr_count - c0, 1);
        chk("R5 write addr", last_wr_addr, 6'h04);
        chk("R5 write data", last_wr_data, 24'h00A55A);
        rd(6'h04, 2, v);
        chk("R2 R4 scratch two-byte readback", v, 24'h00A55A);
        spi_xfer(8'h44, 2, 24'h0, -1, v, c0[0]);
        chk("R1 bit6 ignored on read", v, 24'h00A55A);
        wr(6'h04, 2, 24'h003C81);
        spi_xfer(8'h04, 2, 24'h0, -1, v, c0[0]);
        chk("R2 R1 second pattern", v, 24'h003C81);
    endtask

    task automatic t_tristate;
        logic [23:0] v;
        logic bad;
        spi_xfer(8'h04, 2, 24'h0, -1, v, bad);
        chk("R3 oe only in read data phase", bad, 0);
        spi_xfer(8'h84, 2, 24'h003C81, -1, v, bad);
        chk("R3 oe low through a write", bad, 0);
    endtask

    task automatic t_wave;
        logic [23:0] v;
        @(negedge clk);
        smp_is_volt = 1'b0; smp_data = 24'h812345; smp_valid = 1'b1;
        @(negedge clk) smp_valid = 1'b0;
        rd(6'h05, 3, v);
        chk("R10 R2 current sample 24-bit", v, 24'h812345);
        @(negedge clk);
        smp_is_volt = 1'b1; smp_data = 24'hFF8001; smp_valid = 1'b1;
        @(negedge clk) smp_valid = 1'b0;
        rd(6'h05, 3, v);
        chk("R10 voltage sample zero filled", v, 24'h008001);
        rd(6'h02, 1, v);
        chk("R10 wave flag set", v[1], 1);
    endtask

    task automatic t_unknown;
        logic [23:0] v;
        int c0;
        rd(6'h3F, 1, v);
        chk("R4 unmapped reads zero", v, 24'h0);
        c0 = wr_count;
        wr(6'h05, 3, 24'h123456);
        chk("R5 write bus pulses for read-only addr", wr_count - c0, 1);
        rd(6'h05, 3, v);
        chk("R5 read-only wave unchanged", v, 24'h008001);
        rd(6'h04, 2, v);
        chk("R5 scratch unaffected", v, 24'h003C81);
    endtask

    task automatic t_irq;
        logic [23:0] v;
        rd(6'h03, 1, v);
        chk("R8 take returns flags", v, 24'h03);
        rd(6'h02, 1, v);
        chk("R8 flags cleared", v, 24'h00);
        wr(6'h01, 1, 24'hFF);
        rd(6'h01, 1, v);
        chk("R5 enable written", v, 24'hFF);
        pulse_evt(0);
        chk("R7 power flag never interrupts", irq_n, 1);
        rd(6'h02, 1, v);
        chk("R7 power flag set by event", v, 24'h01);
        pulse_evt(2);
        chk("R6 enabled flag pulls irq low", irq_n, 0);
        rd(6'h02, 1, v);
        chk("R8 peek returns flags", v, 24'h05);
        chk("R8 peek keeps irq low", irq_n, 0);
        rd(6'h03, 1, v);
        chk("R8 take returns flags", v, 24'h05);
        chk("R8 take releases irq", irq_n, 1);
        wr(6'h01, 1, 24'h00);
        pulse_evt(2);
        chk("R6 disabled flag keeps irq high", irq_n, 1);
        wr(6'h01, 1, 24'h04);
        chk("R6 enabling a pending flag asserts irq", irq_n, 0);
        rd(6'h03, 1, v);
        wr(6'h01, 1, 24'h00);
    endtask

    task automatic t_race;
        logic [23:0] v;
        logic [23:0] after;
        logic bad;
        for (int off = 0; off < 8; off++) begin
            fork
                spi_xfer(8'h03, 1, 24'h0, -1, v, bad);
                begin
                    @(posedge mark);
                    repeat (off) @(negedge clk);
                    evt[3] = 1'b1;
                    @(negedge clk) evt[3] = 1'b0;
                end
            join
            rd(6'h02, 1, after);
            chk("R9 event seen exactly once around clear", v[3] ^ after[3], 1);
            rd(6'h03, 1, after);
        end
    endtask

    task automatic t_abort;
        logic [23:0] v;
        logic bad;
        int c0;
        c0 = wr_count;
        spi_xfer(8'h84, 2, 24'h001234, 12, v, bad);
        chk("R11 no write after abort in data", wr_count - c0, 0);
        rd(6'h04, 2, v);
        chk("R11 scratch kept after abort", v, 24'h003C81);
        spi_xfer(8'h84, 2, 24'h001234, 3, v, bad);
        chk("R11 no write after abort in command", wr_count - c0, 0);
        rd(6'h04, 2, v);
        chk("R11 next command decoded cleanly", v, 24'h003C81);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_read();
        t_tristate();
        t_wave();
        t_unknown();
        t_irq();
        t_race();
        t_abort();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule